// File: doc/BRIEF.md
# Multimode 16-bit Down-Counting Timer

This block is a programmable timer built around a 16-bit down counter. A bank of eight tick sources, each a one-cycle enable strobe in the timer's clock domain, feeds a selector. The strobe that is chosen passes through a private prescaler, which divides it by a programmable ratio, and then reaches the counter. The counter loads from a reload value on a start or a retrigger. It steps down by one on each prescaled tick and reports a terminal count when a step begins from 1 or from 0.

The mode input picks one of four behaviours: one-shot, rate generator, square wave and retriggerable one-shot. A polarity input sets the level of the output pin. A sticky interrupt flag records every terminal count until the host clears it. Two or more instances may sit side by side and share the same source strobes with no interaction between them.

Every port is a plain control or status pin. Nothing streams through the block, so it has no valid/ready handshake and nothing can apply back-pressure.

Top module: `mm_timer16`

## Requirements
- R1: After reset `count_o` is 0, `running_o` is 0, `irq_o` is 0, and the internal output level is inactive, so `tmr_out_o` equals `!out_pol_i`.
- R2: With a source that strobes every cycle, the time from the start edge to the terminal count is max(reload,1)×(psc_div_i+1) clock cycles. The longest run at a ratio of 1 is therefore 65535 cycles.
- R3: Only strobes of source `src_sel_i` (index i selects `src_tick_i[i]`) advance the prescaler. While the selected source never strobes, the count holds.
- R4: In mode 0 (one-shot) the output level is active from the start edge until the terminal count. At the terminal count it goes inactive, `count_o` becomes 0 and `running_o` drops, and the counter stays halted.
- R5: In mode 1 (rate generator) the output level is inactive after start and is active for exactly one clock cycle after each terminal count. The counter reloads from `reload_i` and keeps running.
- R6: In mode 2 (square wave) the output level is active after start and toggles at each terminal count. The counter reloads, so each half period lasts one full count.
- R7: In mode 3 (retriggerable one-shot) a `retrig_i` pulse reloads the count and restarts the prescaler, and the run then lasts a full count from the retrigger. In modes 0 to 2, `retrig_i` has no effect on the count.
- R8: `irq_o` is set at every terminal count and stays set until a cycle with `irq_clr_i` high clears it. When a terminal count and a clear fall in the same cycle, the set wins.
- R9: When `out_pol_i` is 1, `tmr_out_o` follows the output level. When `out_pol_i` is 0, it is the inverse of the level.
- R10: `count_o` drops by exactly one per prescaled tick. `start_i` loads the count and restarts the prescaler at phase zero, and it takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick_i | input | 8 | One-cycle enable strobes of the eight tick sources |
| mode_i | input | 2 | 0 one-shot, 1 rate, 2 square wave, 3 retriggerable one-shot |
| src_sel_i | input | 3 | Index of the tick source to use |
| psc_div_i | input | 4 | Prescaler ratio minus one |
| out_pol_i | input | 1 | 1 = active-high output, 0 = active-low |
| reload_i | input | 16 | Value loaded on start, retrigger and automatic reload |
| start_i | input | 1 | One-cycle pulse that loads and starts the counter |
| retrig_i | input | 1 | One-cycle retrigger pulse, honoured in mode 3 only |
| irq_clr_i | input | 1 | Write-one-to-clear pulse for the interrupt flag |
| count_o | output | 16 | Current counter value |
| running_o | output | 1 | Counter is armed and counting |
| tmr_out_o | output | 1 | Output pin level after polarity |
| irq_o | output | 1 | Sticky terminal-count interrupt |

## Verification
The bench targets the off-by-one edges of the run length: reload 0, the largest reload of 65535, and the largest prescaler ratio. A design that counted the load edge as a tick, or that let the prescaler keep its old phase across a start, would end each run one cycle or one partial tick off. A retrigger arrives mid-run in mode 3 and again in mode 0. A design that ignored it in the first case, or honoured it in the second, would give a run of the wrong length. A source that never strobes checks that no other source leaks through the selector. The rate-mode pulse is checked to last exactly one clock, and the square-wave output is checked to hold for a full count before it toggles back. The interrupt flag is checked to persist until cleared, so a flag that was only a pulse would be reported.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic [1:0] {
    MODE_ONESHOT = 2'd0,
    MODE_RATE    = 2'd1,
    MODE_SQUARE  = 2'd2,
    MODE_RETRIG  = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/tmr16_src_mux.sv
module tmr16_src_mux #(
  parameter int N_SRC = 8,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] src_tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  // Index compare per source; an index past N_SRC selects nothing.
  always_comb begin
    tick_o = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (sel_i == SEL_W'(i)) tick_o = src_tick_i[i];
    end
  end
endmodule

// File: rtl/tmr16_prescale.sv
module tmr16_prescale #(
  parameter int PSC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [PSC_W-1:0] div_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] phase;
  logic             wrap;

  assign wrap   = (phase == div_i);
  assign tick_o = en_i & wrap & ~clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (clr_i)   phase <= '0;
    else if (en_i)    phase <= wrap ? '0 : phase + PSC_W'(1);
  end
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_mode_e        mode_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic             irq_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             running_o,
  output logic             level_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt;
  logic             running, level, irq;
  logic             step, tc;

  // A load outranks any tick arriving in the same cycle.
  assign step = tick_i & running & ~load_i;
  assign tc   = step & (cnt <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
      level   <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (load_i) begin
        cnt     <= reload_i;
        running <= 1'b1;
        level   <= (mode_i != MODE_RATE);
      end else if (tc) begin
        unique case (mode_i)
          MODE_RATE: begin
            cnt   <= reload_i;
            level <= 1'b1;
          end
          MODE_SQUARE: begin
            cnt   <= reload_i;
            level <= ~level;
          end
          default: begin
            cnt     <= '0;
            running <= 1'b0;
            level   <= 1'b0;
          end
        endcase
      end else begin
        if (step) cnt <= cnt - CNT_W'(1);
        if (mode_i == MODE_RATE) level <= 1'b0;
      end

      if (tc)             irq <= 1'b1;
      else if (irq_clr_i) irq <= 1'b0;
    end
  end

  assign count_o   = cnt;
  assign running_o = running;
  assign level_o   = level;
  assign irq_o     = irq;
endmodule

// File: rtl/mm_timer16.sv
module mm_timer16
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_SRC = 8,
  parameter int PSC_W = 4,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_tick_i,
  input  logic [1:0]       mode_i,
  input  logic [SEL_W-1:0] src_sel_i,
  input  logic [PSC_W-1:0] psc_div_i,
  input  logic             out_pol_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             start_i,
  input  logic             retrig_i,
  input  logic             irq_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             running_o,
  output logic             tmr_out_o,
  output logic             irq_o
);
  tmr_mode_e mode;
  logic      src_tick, psc_tick, load, level;

  assign mode = tmr_mode_e'(mode_i);
  assign load = start_i | (retrig_i & (mode == MODE_RETRIG));

  tmr16_src_mux #(.N_SRC(N_SRC)) u_mux (
    .src_tick_i(src_tick_i),
    .sel_i     (src_sel_i),
    .tick_o    (src_tick)
  );

  tmr16_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (load),
    .en_i  (src_tick & running_o),
    .div_i (psc_div_i),
    .tick_o(psc_tick)
  );

  tmr16_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode),
    .reload_i (reload_i),
    .load_i   (load),
    .tick_i   (psc_tick),
    .irq_clr_i(irq_clr_i),
    .count_o  (count_o),
    .running_o(running_o),
    .level_o  (level),
    .irq_o    (irq_o)
  );

  assign tmr_out_o = out_pol_i ? level : ~level;
endmodule

// File: rtl/mm_timer16_chk.sv
module mm_timer16_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic             out_pol_i,
  input logic             start_i,
  input logic             retrig_i,
  input logic             irq_clr_i,
  input logic [CNT_W-1:0] count_o,
  input logic             running_o,
  input logic             tmr_out_o,
  input logic             irq_o
);
  // R8: flag persists without a clear
  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr_i) |=> irq_o);

  // R8: clear takes effect when no terminal count can coincide
  a_r8_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr_i && (count_o > CNT_W'(1) || !running_o)) |=> !irq_o);

  // R10: count moves by at most one away from a load or expiry
  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && !start_i && !retrig_i && count_o > CNT_W'(1)) |=>
      (count_o == $past(count_o) || count_o == $past(count_o) - CNT_W'(1)));

  // R4: a halted counter stays halted until a load
  a_r4_halted_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && !start_i && !(retrig_i && mode_i == 2'd3)) |=>
      ($stable(count_o) && !running_o));

  // R5: rate pulse lasts a single clock
  a_r5_rate_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd1 && running_o && !start_i && count_o > CNT_W'(1) &&
     tmr_out_o == out_pol_i) |=> (tmr_out_o != out_pol_i));
endmodule

bind mm_timer16 mm_timer16_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_mm_timer16.sv
module tb_mm_timer16;
  typedef struct packed {
    logic [1:0]  mode;
    logic [3:0]  psc;
    logic [15:0] rld;
    logic        pol;
  } vec_t;

  localparam int VN = 7;
  localparam vec_t VECS [VN] = '{
    '{2'd0, 4'd0,  16'd5, 1'b1},
    '{2'd0, 4'd2,  16'd4, 1'b0},
    '{2'd1, 4'd0,  16'd6, 1'b1},
    '{2'd1, 4'd1,  16'd3, 1'b0},
    '{2'd2, 4'd0,  16'd4, 1'b1},
    '{2'd3, 4'd3,  16'd2, 1'b1},
    '{2'd0, 4'd15, 16'd2, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src_tick = 8'hFD;
  logic [1:0]  mode = '0;
  logic [2:0]  sel = '0;
  logic [3:0]  psc = '0;
  logic        pol = 1'b1;
  logic [15:0] rld = '0;
  logic        start = 1'b0, retrig = 1'b0, clr = 1'b0;
  logic [15:0] count;
  logic        running, tout, irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mm_timer16 dut (
    .clk(clk), .rst_n(rst_n), .src_tick_i(src_tick), .mode_i(mode),
    .src_sel_i(sel), .psc_div_i(psc), .out_pol_i(pol), .reload_i(rld),
    .start_i(start), .retrig_i(retrig), .irq_clr_i(clr),
    .count_o(count), .running_o(running), .tmr_out_o(tout), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called just after a negedge; returns after the load edge's negedge.
  task automatic launch(input logic [1:0] m, input logic [3:0] p,
                        input logic [15:0] r, input logic pl);
    mode = m; psc = p; rld = r; pol = pl; start = 1'b1; clr = 1'b1;
    @(negedge clk);
    start = 1'b0; clr = 1'b0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq && n < 70000);
  endtask

  initial begin
    int n, exp_n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(count == 0 && !running, "R1 count/running", count, 0);
    chk(!irq, "R1 irq", irq, 0);
    chk(tout == 1'b0, "R1 out idle", tout, 0);

    for (int i = 0; i < VN; i++) begin
      vec_t v = VECS[i];
      logic act = v.pol;
      exp_n = ((v.rld == 0) ? 1 : int'(v.rld)) * (int'(v.psc) + 1);
      launch(v.mode, v.psc, v.rld, v.pol);
      chk(count == v.rld && running, "R10 load", count, v.rld);
      chk(tout == ((v.mode == 2'd1) ? !act : act), "R9 start level", tout,
          (v.mode == 2'd1) ? !act : act);
      wait_irq(n);
      chk(n == exp_n, "R2 duration", n, exp_n);
      if (v.mode == 2'd0 || v.mode == 2'd3) begin
        chk(tout == !act && !running && count == 0, "R4 expiry", tout, !act);
      end else if (v.mode == 2'd1) begin
        chk(tout == act && count == v.rld, "R5 pulse on", tout, act);
        @(negedge clk);
        chk(tout == !act && running, "R5 pulse off", tout, !act);
      end else begin
        chk(tout == !act && count == v.rld, "R6 first toggle", tout, !act);
        n = 0;
        do begin
          @(negedge clk);
          n++;
        end while (tout != act && n < 1000);
        chk(n == exp_n, "R6 half period", n, exp_n);
      end
    end

    // R8 sticky and clear (last vector was one-shot)
    repeat (10) @(negedge clk);
    chk(irq, "R8 sticky", irq, 1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(!irq, "R8 clear", irq, 0);

    // R2 reload zero expires after one tick
    launch(2'd0, 4'd0, 16'd0, 1'b1);
    wait_irq(n);
    chk(n == 1, "R2 reload zero", n, 1);

    // R7 retrigger in mode 3
    launch(2'd3, 4'd0, 16'd6, 1'b1);
    repeat (3) @(negedge clk);
    chk(count == 3, "R10 step per tick", count, 3);
    retrig = 1'b1;
    @(negedge clk);
    retrig = 1'b0;
    chk(count == 6, "R7 retrig reload", count, 6);
    wait_irq(n);
    chk(n == 6, "R7 retrig run", n, 6);

    // R7 retrigger ignored in mode 0
    launch(2'd0, 4'd0, 16'd6, 1'b1);
    repeat (3) @(negedge clk);
    retrig = 1'b1;
    @(negedge clk);
    retrig = 1'b0;
    chk(count == 2, "R7 retrig ignored", count, 2);
    wait_irq(n);
    chk(n == 2, "R7 ignored run", n, 2);

    // R3 silent source holds the count
    sel = 3'd1;
    launch(2'd0, 4'd0, 16'd4, 1'b1);
    repeat (20) @(negedge clk);
    chk(count == 4 && !irq, "R3 silent source", count, 4);
    sel = 3'd0;
    wait_irq(n);
    chk(n == 4, "R3 switched source", n, 4);

    // R2 longest run
    launch(2'd0, 4'd0, 16'hFFFF, 1'b1);
    wait_irq(n);
    chk(n == 65535, "R2 max reload", n, 65535);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule